// File: doc/BRIEF.md
# Serial Receive Queue with Switchable Depth

This block is the receive-side buffer of a serial port. Each word it holds is twelve bits: eight data bits with four status bits above them, such as the error flags or a line-break marker. The deserializer offers words on the write side. Software pops one word per data-register read. The same pop copies the status bits of that word into a status register, which software can later clear.

A mode bit picks the capacity. When the bit is set, the queue holds `DEPTH` words in a ring. When it is clear, the queue holds one word and both pointers stay at slot 0. Any write that flips the mode bit empties the queue. A receive interrupt request rises when the fill count reaches the trigger level. A pop that leaves the count one below the trigger drops it again. A word offered while the queue is full is discarded, and an overrun pulse reports the loss.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, the block is in single-word mode. The empty flag is 1, and the full flag, accept flag complement, interrupt request, status register and overrun output are all 0; the accept output is 1.
- R2: The effective capacity is 1 when the mode bit is 0 and `DEPTH` (16) when it is 1. `can_accept` is high exactly while the count is below that capacity. `rx_full` is high exactly when the count equals it.
- R3: A mode write whose value differs from the current mode empties the queue: the count and read pointer become 0, `rx_empty` is set and `rx_full` is cleared. A push or pop in that same cycle is ignored. A mode write with an unchanged value leaves the contents alone.
- R4: Words leave in the order they arrived, including across the wrap of the ring. `rd_word` always shows the word at the read pointer.
- R5: An accepted push clears `rx_empty`. A pop of the last word sets it.
- R6: `rx_irq` is set when an accepted push brings the count to `TRIG` (default 1). It is cleared when a pop leaves the count at `TRIG`-1; with `TRIG` = 1 this includes a pop on an empty queue. A flush does not change `rx_irq`.
- R7: A pop on an empty queue moves no pointer and changes no count. It returns the word at the read pointer; in single-word mode that is the last word stored.
- R8: A push offered while `can_accept` is low is dropped and leaves the stored words unchanged. `overrun` is high for exactly the next cycle.
- R9: Every pop that is not overridden by a flush loads bits 11:8 of `rd_word` into `rx_status`. A line break arrives as word 0x400, which pops as data 0x00 with status 4'b0100.
- R10: `status_clr` zeroes `rx_status` unless a pop happens in the same cycle; when both occur, the pop's load wins.
- R11: A push and a pop in the same cycle both act on the state from before that cycle. The pop takes the head, and the push is accepted only if the old count was below capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Strobe: line-control write carrying the mode bit |
| mode_buf_en | input | 1 | Mode bit value written (1 = full depth, 0 = single word) |
| push_valid | input | 1 | Word offered by the deserializer |
| push_word | input | 12 | Offered word: status in 11:8, data in 7:0 |
| pop | input | 1 | Data-register read strobe |
| status_clr | input | 1 | Write strobe to the receive-status register |
| rd_word | output | 12 | Word at the read pointer |
| rx_status | output | 4 | Latched status bits of the last popped word |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue at effective capacity |
| can_accept | output | 1 | A push this cycle would be stored |
| rx_irq | output | 1 | Receive-level interrupt request |
| overrun | output | 1 | One-cycle pulse after a dropped push |

## Verification
The bench fills the queue to every level from 1 to 16 and drains it. Because each round starts where the last one left the read pointer, this sweep shows whether the order survives the wrap, and it separates the full flag from the empty flag at each count.

Single-word mode is tried with overfill, with pops on an empty queue and with a flush while the request is raised. These cases tell the stale-read rule apart from the interrupt-retention rule.

Three further patterns each check one edge case:
- Simultaneous push and pop at a partial level and at single-word capacity show whether the accept decision uses the old count.
- A break word checks that the status latch is fed from the popped word.
- A rewrite of an unchanged mode bit, set against a real toggle, checks that only a change flushes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 4;
  localparam int WORD_W = DATA_W + STAT_W;

  // Ring index arithmetic: capacity is a power of two, so wrap is a mask.
  function automatic int unsigned ring_slot(input int unsigned base,
                                            input int unsigned offset,
                                            input int unsigned capacity);
    return (base + offset) & (capacity - 1);
  endfunction

  function automatic int unsigned capacity_of(input logic buf_en,
                                              input int unsigned full_depth);
    return buf_en ? full_depth : 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WORD_W-1:0]        rd_word
);
  localparam int PW = $clog2(DEPTH);

  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign slot_hit[i] = wr_en && (wr_idx == PW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_hit[i]) slot_q[i] <= wr_word;
    end
  end

  assign rd_word = slot_q[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr,
  input  logic                     mode_buf_en,
  input  logic                     push_valid,
  input  logic                     pop,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     pop_evt,
  output logic                     rx_empty,
  output logic                     rx_full,
  output logic                     can_accept,
  output logic                     rx_irq,
  output logic                     overrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic          buf_en_q;
  logic [PW-1:0] rp_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] cap;
  logic          irq_q, ovr_q;

  // Named internal events
  logic mode_flip, push_ok, push_drop, pop_take;

  assign cap        = CW'(rxq_pkg::capacity_of(buf_en_q, DEPTH));
  assign mode_flip  = mode_wr && (mode_buf_en != buf_en_q);
  assign can_accept = cnt_q < cap;
  assign push_ok    = !mode_flip && push_valid && can_accept;
  assign push_drop  = !mode_flip && push_valid && !can_accept;
  assign pop_evt    = !mode_flip && pop;
  assign pop_take   = pop_evt && (cnt_q != '0);
  assign cnt_nx     = cnt_q + CW'(push_ok) - CW'(pop_take);

  assign wr_en  = push_ok;
  assign wr_idx = PW'(rxq_pkg::ring_slot(32'(rp_q), 32'(cnt_q), 32'(cap)));
  assign rd_idx = rp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en_q <= 1'b0;
      rp_q     <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      ovr_q <= push_drop;
      if (mode_wr) buf_en_q <= mode_buf_en;
      if (mode_flip) begin
        rp_q  <= '0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nx;
        if (pop_take)
          rp_q <= PW'(rxq_pkg::ring_slot(32'(rp_q), 1, 32'(cap)));
        if (pop_evt && cnt_nx == CW'(TRIG - 1))
          irq_q <= 1'b0;
        else if (push_ok && cnt_nx == CW'(TRIG))
          irq_q <= 1'b1;
      end
    end
  end

  assign rx_empty = (cnt_q == '0);
  assign rx_full  = (cnt_q == cap);
  assign rx_irq   = irq_q;
  assign overrun  = ovr_q;

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);
  // R2
  single_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en_q |-> rd_idx == '0);
  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (rx_empty && !rx_full && rd_idx == '0));
  // R6
  flush_irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> rx_irq == $past(rx_irq));
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_evt && cnt_q == CW'(TRIG - 1)) |=> rx_irq);
  // R7
  empty_pop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_empty && !mode_wr && !push_valid) |=> ($stable(rd_idx) && rx_empty));
  // R8
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !mode_wr && !can_accept) |=> overrun);
  // R8
  overrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> !overrun);
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int WORD_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pop_evt,
  input  logic                     status_clr,
  input  logic [WORD_W-1:0]        head_word,
  output logic [WORD_W-DATA_W-1:0] rx_status
);
  localparam int SW = WORD_W - DATA_W;

  logic [SW-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= '0;
    else if (pop_evt)    stat_q <= head_word[WORD_W-1:DATA_W];
    else if (status_clr) stat_q <= '0;
  end

  assign rx_status = stat_q;

  // R9
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> rx_status == $past(head_word[WORD_W-1:DATA_W]));
  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !pop_evt) |=> rx_status == '0);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_wr,
  input  logic                      mode_buf_en,
  input  logic                      push_valid,
  input  logic [rxq_pkg::WORD_W-1:0] push_word,
  input  logic                      pop,
  input  logic                      status_clr,
  output logic [rxq_pkg::WORD_W-1:0] rd_word,
  output logic [rxq_pkg::STAT_W-1:0] rx_status,
  output logic                      rx_empty,
  output logic                      rx_full,
  output logic                      can_accept,
  output logic                      rx_irq,
  output logic                      overrun
);
  localparam int PW = $clog2(DEPTH);

  logic          wr_en, pop_evt;
  logic [PW-1:0] wr_idx, rd_idx;

  rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_buf_en(mode_buf_en),
    .push_valid(push_valid), .pop(pop),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .pop_evt(pop_evt),
    .rx_empty(rx_empty), .rx_full(rx_full), .can_accept(can_accept),
    .rx_irq(rx_irq), .overrun(overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .WORD_W(rxq_pkg::WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(push_word),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  rxq_status #(.WORD_W(rxq_pkg::WORD_W), .DATA_W(rxq_pkg::DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .pop_evt(pop_evt), .status_clr(status_clr),
    .head_word(rd_word), .rx_status(rx_status)
  );
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 0, mode_buf_en = 0, push_valid = 0, pop = 0, status_clr = 0;
  logic [11:0] push_word = '0;
  logic [11:0] rd_word;
  logic [3:0]  rx_status;
  logic        rx_empty, rx_full, can_accept, rx_irq, overrun;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Bench model
  logic [11:0] q[$];
  bit          m_en = 0, m_irq = 0, m_ovr = 0;
  logic [3:0]  m_rsr = '0;
  logic [11:0] m_stale = '0;

  always #4 clk = ~clk; // 125 MHz

  uart_rx_queue u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_buf_en(mode_buf_en),
    .push_valid(push_valid), .push_word(push_word), .pop(pop),
    .status_clr(status_clr), .rd_word(rd_word), .rx_status(rx_status),
    .rx_empty(rx_empty), .rx_full(rx_full), .can_accept(can_accept),
    .rx_irq(rx_irq), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 173 + 29) ^ (i << 3));
  endfunction

  task automatic check_all();
    int cap;
    cap = m_en ? 16 : 1;
    check("R5 empty", int'(rx_empty), int'(q.size() == 0));
    check("R2 full", int'(rx_full), int'(q.size() == cap));
    check("R2 can_accept", int'(can_accept), int'(q.size() < cap));
    check("R6 irq", int'(rx_irq), int'(m_irq));
    check("R9 status", int'(rx_status), int'(m_rsr));
    check("R8 overrun", int'(overrun), int'(m_ovr));
    if (q.size() > 0) check("R4 head word", int'(rd_word), int'(q[0]));
  endtask

  task automatic op(input bit p, input logic [11:0] w, input bit r,
                    input bit c, input bit lw, input bit le);
    bit tog, acc;
    int cap, n;
    logic [11:0] popped;
    @(negedge clk);
    push_valid = p; push_word = w; pop = r; status_clr = c;
    mode_wr = lw; mode_buf_en = le;
    tog = lw && (le != m_en);
    cap = m_en ? 16 : 1;
    n = q.size();
    m_ovr = 0;
    if (tog) begin
      q.delete();
      m_en = le;
    end else begin
      if (lw) m_en = le;
      acc = p && (n < cap);
      m_ovr = p && !acc;
      if (r) begin
        popped = (n > 0) ? q[0] : m_stale;
        m_rsr = popped[11:8];
        if (n > 0) void'(q.pop_front());
      end else if (c) m_rsr = '0;
      if (acc) begin
        q.push_back(w);
        if (!m_en) m_stale = w;
      end
      if (r && q.size() == 0) m_irq = 0;
      else if (acc && q.size() == 1) m_irq = 1;
    end
    @(negedge clk);
    push_valid = 0; pop = 0; status_clr = 0; mode_wr = 0;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", int'(rx_empty), 1);
    check("R1 full", int'(rx_full), 0);
    check("R1 accept", int'(can_accept), 1);
    check("R1 irq", int'(rx_irq), 0);
    check("R1 status", int'(rx_status), 0);
    check("R1 overrun", int'(overrun), 0);

    // Single-word mode: fill, overfill, drain, stale pops
    op(1, 12'hA5C, 0, 0, 0, 0);
    op(1, 12'h3F1, 0, 0, 0, 0);             // R8 dropped
    op(0, '0, 1, 0, 0, 0);
    op(0, '0, 1, 0, 0, 0);                  // R7 empty pop
    check("R7 stale word", int'(rd_word), int'(12'hA5C));
    // R11 in single mode: push with pop when full is dropped
    op(1, 12'h611, 0, 0, 0, 0);
    op(1, 12'h722, 1, 0, 0, 0);
    check("R11 single push refused", int'(overrun), 1);
    op(1, 12'h933, 0, 0, 0, 0);             // irq rises
    // R3 flush toggling to buffered; R6 irq kept
    op(0, '0, 0, 0, 1, 1);
    check("R3 flushed empty", int'(rx_empty), 1);
    check("R6 irq kept on flush", int'(rx_irq), 1);
    op(0, '0, 1, 0, 0, 0);                  // R6 empty pop clears irq
    check("R6 irq cleared by empty pop", int'(rx_irq), 0);

    // Buffered sweep of every fill level, pointer keeps moving across rounds
    k = 0;
    for (int lvl = 1; lvl <= 16; lvl++) begin
      for (int j = 0; j < lvl; j++) begin op(1, pat(k), 0, 0, 0, 0); k++; end
      for (int j = 0; j < lvl; j++) op(0, '0, 1, 0, 0, 0);
    end

    // Overfill in buffered mode
    for (int j = 0; j < 16; j++) begin op(1, pat(k), 0, 0, 0, 0); k++; end
    op(1, 12'hFFF, 0, 0, 0, 0);             // R8
    check("R8 overrun buffered", int'(overrun), 1);
    for (int j = 0; j < 16; j++) op(0, '0, 1, 0, 0, 0);

    // Same-value mode write keeps data
    for (int j = 0; j < 3; j++) begin op(1, pat(k), 0, 0, 0, 0); k++; end
    op(0, '0, 0, 0, 1, 1);
    check("R3 same mode keeps data", int'(rx_empty), 0);
    // R11 simultaneous push and pop at partial level
    op(1, 12'h5E7, 1, 0, 0, 0);
    check("R11 head after push+pop", int'(rd_word), int'(q[0]));
    while (q.size() > 0) op(0, '0, 1, 0, 0, 0);

    // R9 line break word
    op(1, 12'h400, 0, 0, 0, 0);
    check("R9 break data", int'(rd_word[7:0]), 0);
    op(0, '0, 1, 0, 0, 0);
    check("R9 break status", int'(rx_status), 4);
    // R10 clear, and pop wins over clear
    op(0, '0, 0, 1, 0, 0);
    check("R10 cleared", int'(rx_status), 0);
    op(1, 12'hB3C, 0, 0, 0, 0);
    op(0, '0, 1, 1, 0, 0);
    check("R10 pop beats clear", int'(rx_status), 4'hB);

    // Toggle back to single mode with data present, push ignored that cycle
    op(1, pat(k), 0, 0, 0, 0); k++;
    op(1, pat(k), 0, 0, 0, 0); k++;
    op(1, 12'h123, 1, 0, 1, 0);
    check("R3 flush ignores push/pop", int'(rx_empty), 1);
    op(1, 12'h2C4, 0, 0, 0, 0);
    check("R2 single full", int'(rx_full), 1);
    op(0, '0, 1, 0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule